// File: doc/BRIEF.md
# Indirect Map Table Access Port

This block gives a host a two-register window onto a small lookup table that a channel multiplexer consults to place bytes in its output frame. The table is not memory-mapped. The host writes a table index into a control register. Bits in that same register then load the index and choose whether the word is written or read. A second register carries the data word in both directions.

To store a word, the host first writes the data register. It then writes the control register with the index, the load bit and the write direction set. The word lands in the table on that clock edge. To fetch a word, the host writes the control register with the index and the load bit set and the direction clear. It then polls the top bit of the control register until that bit drops, and reads the data register.

The multiplexer reads the table through a separate combinational lookup port. That port does not interact with the host window.

Top module: `map_ram_port`

## Requirements
- R1: After reset, both host registers read as zero and every table word reads as zero on the lookup port.
- R2: A control write with bit 12 clear updates the index field readback but starts no transfer. The table is unchanged and bit 31 stays 0.
- R3: A control write with bit 12 and bit 14 both set, while idle, stores the current data register contents at the table index in bits [3:0]. The word is visible on the lookup port after that clock edge, and the data register keeps its value.
- R4: A control write with bit 12 set and bit 14 clear, while idle, sets bit 31 from the next clock edge. Bit 31 stays set for exactly two cycles. In the cycle it clears, the data register holds the table word at the given index.
- R5: While bit 31 is set, control writes are ignored. The index field, bit 12 and bit 14 read back unchanged, and no second transfer starts.
- R6: While bit 31 is set, host writes to the data register are ignored. After bit 31 clears, the data register holds the fetched word.
- R7: Control readback places the index in bits [3:0], the last accepted load bit in bit 12, the last accepted direction bit in bit 14 and the busy flag in bit 31. All other bits read 0.
- R8: Bit 31 is read-only. Writing 1 to it never sets the busy flag.
- R9: A full sweep that writes indices 0 to 15 in order, followed by indirect reads of each index, returns every stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe, one cycle per write |
| host_sel | input | 1 | Register select: 0 control, 1 data |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational readback of the selected register |
| lkp_addr | input | 4 | Multiplexer lookup index |
| lkp_data | output | 32 | Table word at the lookup index |

## Verification
The checker assumes that the host asserts host_wr for a single cycle per register access. It also assumes that host_sel and host_wdata are valid whenever host_wr is high. The bench drives every input on the falling clock edge through one write task, which raises the strobe for exactly one rising edge. The busy-window properties assume that a read cannot be restarted while one is in flight. The bench deliberately issues control and data writes inside that window to show that they are dropped.

// File: rtl/map_port_pkg.sv
// Shared constants for the indirect map table port: host register
// selects and fixed bit positions inside the control register.
// Assumes a 32-bit host bus; the busy flag sits in the top bit.
package map_port_pkg;
    localparam int HOST_W     = 32;
    localparam int LOAD_BIT   = 12;
    localparam int DIR_BIT    = 14;
    localparam int BUSY_BIT   = 31;
    localparam int READ_LAT   = 2;
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_DATA = 1'b1;
endpackage

// File: rtl/map_ctrl_reg.sv
// Control register of the indirect port. It holds the index field and
// the load and direction bits for readback. It latches the access index
// and raises one-cycle start pulses for a table write or read.
// Assumes the caller has already decoded the field bits from the host bus.
module map_ctrl_reg #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              busy,
    input  logic [ADDR_W-1:0] f_addr,
    input  logic              f_load,
    input  logic              f_dir,
    output logic [ADDR_W-1:0] addr_q,
    output logic              load_q,
    output logic              dir_q,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              start_wr,
    output logic              start_rd
);
    logic accept;

    // Accept control writes only while no read is in flight.
    always_comb begin
        accept   = ctrl_wr && !busy;
        start_wr = accept && f_load && f_dir;
        start_rd = accept && f_load && !f_dir;
    end

    // Hold the readback fields of the last accepted control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            load_q <= 1'b0;
            dir_q  <= 1'b0;
        end else if (accept) begin
            addr_q <= f_addr;
            load_q <= f_load;
            dir_q  <= f_dir;
        end
    end

    // Latch the access index only when the load bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_addr <= '0;
        end else if (accept && f_load) begin
            acc_addr <= f_addr;
        end
    end
endmodule

// File: rtl/map_read_seq.sv
// Read sequencer. A start pulse raises busy. The first stage enables the
// table's registered read. The second stage loads the data register and
// drops busy, which gives the fixed two-cycle read latency.
// Assumes start is never raised while busy is set.
module map_read_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic fetch_en,
    output logic load_en
);
    logic [map_port_pkg::READ_LAT-1:0] stage_q;

    // Shift the read token through its latency stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[map_port_pkg::READ_LAT-2:0], start};
        end
    end

    // Busy rises with start and falls when the last stage retires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
        end else if (stage_q[map_port_pkg::READ_LAT-1]) begin
            busy <= 1'b0;
        end
    end

    // Name the stage taps for the table and the data register.
    always_comb begin
        fetch_en = stage_q[0];
        load_en  = stage_q[map_port_pkg::READ_LAT-1];
    end
endmodule

// File: rtl/map_store.sv
// Map table storage. It has one synchronous write port, one registered
// read port for the host path and one combinational lookup port for the
// multiplexer datapath. Every word resets to zero.
// Assumes write and host read never target the same cycle's result.
module map_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rd_q,
    input  logic [ADDR_W-1:0] lkp_addr,
    output logic [DATA_W-1:0] lkp_data
);
    logic [DATA_W-1:0] words [DEPTH];

    // Write one word per cycle and clear all words on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) words[w] <= '0;
        end else if (we) begin
            for (int w = 0; w < DEPTH; w++) begin
                if (waddr == ADDR_W'(w)) words[w] <= wdata;
            end
        end
    end

    // Register the host-side read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (re) begin
            rd_q <= words[raddr];
        end
    end

    // Serve the datapath lookup combinationally.
    always_comb lkp_data = words[lkp_addr];
endmodule

// File: rtl/map_ram_port.sv
// Top of the indirect map table port. It decodes host writes to the
// control and data registers, owns the data register and muxes the
// readback. The control logic, read sequencer and table storage sit in
// submodules.
// Assumes a one-cycle host_wr strobe per register access.
module map_ram_port #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [ADDR_W-1:0] lkp_addr,
    output logic [DATA_W-1:0] lkp_data
);
    import map_port_pkg::*;

    logic              ctrl_wr, data_wr;
    logic [ADDR_W-1:0] f_addr;
    logic              f_load, f_dir;
    logic [ADDR_W-1:0] addr_q, acc_addr;
    logic              load_q, dir_q;
    logic              start_wr, start_rd;
    logic              busy, fetch_en, load_en;
    logic [DATA_W-1:0] data_q, rd_q, ctrl_view;

    generate
        if (DATA_W != HOST_W || ADDR_W > LOAD_BIT) begin : g_bad_cfg
            initial $error("map_ram_port: unsupported parameter set");
        end
    endgenerate

    // Decode host strobes and pull the control fields off the bus.
    always_comb begin
        ctrl_wr = host_wr && (host_sel == SEL_CTRL);
        data_wr = host_wr && (host_sel == SEL_DATA);
        f_addr  = host_wdata[ADDR_W-1:0];
        f_load  = host_wdata[LOAD_BIT];
        f_dir   = host_wdata[DIR_BIT];
    end

    map_ctrl_reg #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .busy     (busy),
        .f_addr   (f_addr),
        .f_load   (f_load),
        .f_dir    (f_dir),
        .addr_q   (addr_q),
        .load_q   (load_q),
        .dir_q    (dir_q),
        .acc_addr (acc_addr),
        .start_wr (start_wr),
        .start_rd (start_rd)
    );

    map_read_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_rd),
        .busy     (busy),
        .fetch_en (fetch_en),
        .load_en  (load_en)
    );

    map_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (start_wr),
        .waddr    (f_addr),
        .wdata    (data_q),
        .re       (fetch_en),
        .raddr    (acc_addr),
        .rd_q     (rd_q),
        .lkp_addr (lkp_addr),
        .lkp_data (lkp_data)
    );

    // Data register: a fetched word takes priority and host writes wait for idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load_en) begin
            data_q <= rd_q;
        end else if (data_wr && !busy) begin
            data_q <= host_wdata;
        end
    end

    // Assemble the control readback word.
    always_comb begin
        ctrl_view                 = '0;
        ctrl_view[ADDR_W-1:0]     = addr_q;
        ctrl_view[LOAD_BIT]       = load_q;
        ctrl_view[DIR_BIT]        = dir_q;
        ctrl_view[BUSY_BIT]       = busy;
    end

    // Return the selected register to the host.
    always_comb host_rdata = (host_sel == SEL_DATA) ? data_q : ctrl_view;
endmodule

// File: rtl/map_ram_port_chk.sv
// Property checker for map_ram_port. It is bound to the top and observes
// the host strobes and the state handed between the submodules.
module map_ram_port_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_sel,
    input logic [DATA_W-1:0] host_wdata,
    input logic              busy,
    input logic              load_en,
    input logic [ADDR_W-1:0] addr_q,
    input logic              load_q,
    input logic              dir_q,
    input logic [DATA_W-1:0] data_q,
    input logic [DATA_W-1:0] rd_q
);
    import map_port_pkg::*;

    // R2
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_CTRL && !busy && !host_wdata[LOAD_BIT]) |=> !busy);

    // R4
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 !busy);

    // R4
    fetch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> data_q == $past(rd_q));

    // R5
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_CTRL && busy) |=>
            ($stable(addr_q) && $stable(load_q) && $stable(dir_q)));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_DATA && busy && !load_en) |=> $stable(data_q));

    // R7
    field_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_CTRL && !busy) |=>
            (load_q == $past(host_wdata[LOAD_BIT]) && dir_q == $past(host_wdata[DIR_BIT])));
endmodule

bind map_ram_port map_ram_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .busy       (busy),
    .load_en    (load_en),
    .addr_q     (addr_q),
    .load_q     (load_q),
    .dir_q      (dir_q),
    .data_q     (data_q),
    .rd_q       (rd_q)
);

// File: tb/map_ram_port_tb.sv
// Directed bench for map_ram_port. It has one task per scenario and
// drives and samples on the falling clock edge.
module map_ram_port_tb;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_sel = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] lkp_addr = '0;
    logic [DW-1:0] lkp_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    map_ram_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .lkp_addr(lkp_addr), .lkp_data(lkp_data)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] cw(input int a, input bit ld, input bit dir);
        return (DW'(ld) << 12) | (DW'(dir) << 14) | DW'(a & 15);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // One-cycle register write: returns at the falling edge after the rising edge.
    task automatic hwrite(input logic sel, input logic [DW-1:0] d);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [DW-1:0] v);
        host_sel = sel; #1; v = host_rdata;
    endtask

    task automatic peek(input int a, output logic [DW-1:0] v);
        lkp_addr = AW'(a); #1; v = lkp_data;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rd_reg(1'b0, v); check("R1 ctrl", v, '0);
        rd_reg(1'b1, v); check("R1 data", v, '0);
        for (int i = 0; i < 16; i++) begin
            peek(i, v); check("R1 word", v, '0);
        end
    endtask

    task automatic t_write(input int a, input logic [DW-1:0] d);
        logic [DW-1:0] v;
        hwrite(1'b1, d);
        hwrite(1'b0, cw(a, 1, 1));
        peek(a, v);     check("R3 stored", v, d);
        rd_reg(1'b1, v); check("R3 data kept", v, d);
        rd_reg(1'b0, v); check("R7 ctrl echo", v, cw(a, 1, 1));
    endtask

    // Read with cycle-exact busy observation.
    task automatic t_read(input int a, input logic [DW-1:0] exp, input string req);
        logic [DW-1:0] v;
        hwrite(1'b0, cw(a, 1, 0));
        rd_reg(1'b0, v); check("R4 busy c1", v, cw(a, 1, 0) | 32'h8000_0000);
        @(negedge clk);
        rd_reg(1'b0, v); check("R4 busy c2", {31'b0, v[31]}, 32'd1);
        @(negedge clk);
        rd_reg(1'b0, v); check("R4 busy clear", v, cw(a, 1, 0));
        rd_reg(1'b1, v); check(req, v, exp);
    endtask

    task automatic t_no_load();
        logic [DW-1:0] v;
        hwrite(1'b1, 32'hDEAD_0007);
        hwrite(1'b0, cw(7, 0, 1));
        rd_reg(1'b0, v); check("R2 index echo", v, cw(7, 0, 1));
        peek(7, v);      check("R2 table untouched", v, '0);
        @(negedge clk);
        rd_reg(1'b0, v); check("R2 no busy", {31'b0, v[31]}, '0);
    endtask

    task automatic t_busy_ctrl();
        logic [DW-1:0] v;
        hwrite(1'b0, cw(3, 1, 0));
        hwrite(1'b0, cw(9, 1, 1));
        rd_reg(1'b0, v); check("R5 ignored", v, cw(3, 1, 0) | 32'h8000_0000);
        @(negedge clk);
        rd_reg(1'b0, v); check("R5 single read", v, cw(3, 1, 0));
        rd_reg(1'b1, v); check("R5 fetched", v, 32'h3333_0003);
        peek(9, v);      check("R5 no write", v, '0);
    endtask

    task automatic t_busy_data();
        logic [DW-1:0] v;
        hwrite(1'b0, cw(3, 1, 0));
        hwrite(1'b1, 32'hBAD0_BAD0);
        @(negedge clk);
        rd_reg(1'b1, v); check("R6 data held", v, 32'h3333_0003);
    endtask

    task automatic t_ro_busy();
        logic [DW-1:0] v;
        hwrite(1'b0, 32'h8000_0005);
        rd_reg(1'b0, v); check("R8 ro bit", v, 32'h0000_0005);
        @(negedge clk);
        rd_reg(1'b0, v); check("R8 still idle", v, 32'h0000_0005);
    endtask

    task automatic t_sweep();
        logic [DW-1:0] v;
        for (int i = 0; i < 16; i++) t_write(i, 32'h5A00_0000 | DW'(i * 32'h0001_0101));
        for (int i = 15; i >= 0; i--) t_read(i, 32'h5A00_0000 | DW'(i * 32'h0001_0101), "R9 sweep");
        peek(15, v); check("R9 lookup", v, 32'h5A0F_0F0F);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_load();
        t_write(3, 32'h3333_0003);
        t_read(3, 32'h3333_0003, "R4 data");
        t_read(7, 32'h0000_0000, "R4 empty word");
        t_busy_ctrl();
        t_busy_data();
        t_ro_busy();
        t_sweep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule